// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps a four-bank SDRAM refreshed. An interval counter advances on each cycle in which `tick_i` is high. Each time it completes a programmed number of ticks, one refresh becomes due. The block then asks the main controller for the command bus with `req_o` and waits for `gnt_i`. If the controller reports that some bank is still open, the block first closes every bank with a precharge-all. It then issues the auto-refresh. After every refresh it holds the bus quiet for the row-cycle gap.

Refreshes that are due but not yet granted are stored in a small saturating counter. When that counter is full, `urgent_o` goes high. A self-refresh request takes the same path to the bus, with the same precharge-all when needed. The block then drops the clock-enable and keeps it low for as long as the request stays high. When the request is released, the block raises the clock-enable and waits one full row-cycle gap. It then issues one auto-refresh before handing the bus back. Every command is counted in whole clock cycles through parameters. Outputs follow the state register directly, so each command appears in the cycle after the edge that decided it.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: While reset is asserted, the command outputs are NOP with clock-enable high (cs_n=0, ras_n=1, cas_n=1, we_n=1, cke=1, a10=0), and `req_o` and `urgent_o` are low.
- R2: One refresh becomes due for every `T_REFI` cycles with `tick_i` high. Cycles with `tick_i` low do not advance the interval.
- R3: `req_o` is high while a refresh is due, while self-refresh is requested, or while a sequence is under way. A sequence starts only from an idle state in which `gnt_i` is high, and its first command appears in the next cycle.
- R4: An auto-refresh is driven as cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1. No bank or row address is supplied with it.
- R5: If `banks_idle_i` is low when the grant is taken, a precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1) comes first. The following refresh or self-refresh entry comes exactly `T_RP` cycles later.
- R6: No command is issued within `T_RC` cycles after an auto-refresh. Refreshes that are due and granted back to back are spaced exactly `T_RC` cycles apart.
- R7: The due-refresh count saturates at `MAX_PEND`, and `urgent_o` is high exactly while the count is at that limit.
- R8: Self-refresh entry is cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=0. cke then stays low with NOP and no refresh for as long as `sr_req_i` stays high.
- R9: cke returns high in the cycle after `sr_req_i` is seen low. An auto-refresh follows exactly `T_RC` cycles after that rise, and the interval count restarts from zero at the exit.
- R10: In every other cycle the outputs are NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Interval counter advances when high |
| gnt_i | input | 1 | Controller grants the command bus |
| banks_idle_i | input | 1 | All four banks are precharged |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| req_o | output | 1 | Bus request to the controller |
| urgent_o | output | 1 | Due-refresh count is at its limit |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| a10_o | output | 1 | Address bit 10 (all-banks select on precharge) |

## Verification
The bench builds the block with `T_RC`=4, `T_RP`=2, `T_REFI`=20 and `MAX_PEND`=3. With these values the block saturates within about a hundred cycles. The run then covers a grant withheld long enough to pass the limit, the drain of the stored refreshes at exact gap spacing, a tick pause that shifts the next refresh, and a complete self-refresh entry and exit, all within about three hundred cycles. The expected cycle of every command is computed in advance from the parameters.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WRP,
      ST_REF,
      ST_WRC,
      ST_SRE,
      ST_SELF,
      ST_XIT
   } rf_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic cke;
      logic a10;
   } cmd_t;

   localparam cmd_t CMD_NOP  = 6'b011110;
   localparam cmd_t CMD_PREA = 6'b001011;
   localparam cmd_t CMD_REF  = 6'b000110;
   localparam cmd_t CMD_SRE  = 6'b000100;
   localparam cmd_t CMD_SLP  = 6'b011100;

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
   parameter int T_REFI   = 1040,
   parameter int MAX_PEND = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   input  logic dec_i,
   output logic pend_nz_o,
   output logic full_o
);
   localparam int CW = (T_REFI > 1) ? $clog2(T_REFI) : 1;
   localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = tick_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (wrap)    cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (MAX_PEND == 1) begin : g_flag
         logic due_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      due_q <= 1'b0;
            else if (clr_i)  due_q <= 1'b0;
            else if (wrap)   due_q <= 1'b1;
            else if (dec_i)  due_q <= 1'b0;
         end
         assign pend_nz_o = due_q;
         assign full_o    = due_q;
      end else begin : g_count
         localparam int PW = $clog2(MAX_PEND + 1);
         localparam logic [PW-1:0] LIM = PW'(MAX_PEND);
         logic [PW-1:0] pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pend_q <= '0;
            else if (clr_i)                      pend_q <= '0;
            else if (wrap && !dec_i && pend_q != LIM) pend_q <= pend_q + 1'b1;
            else if (dec_i && !wrap && pend_q != '0)  pend_q <= pend_q - 1'b1;
         end
         assign pend_nz_o = (pend_q != '0);
         assign full_o    = (pend_q == LIM);

         assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q <= LIM);
      end
   endgenerate

endmodule

// File: rtl/rfsh_gap_timer.sv
module rfsh_gap_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_i,
   input  logic [TW-1:0] ld_val_i,
   output logic          done_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (ld_i)          cnt_q <= ld_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
   import sdram_rfsh_pkg::*;
#(
   parameter int T_RC = 9,
   parameter int T_RP = 3,
   parameter int TW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gnt_i,
   input  logic          banks_idle_i,
   input  logic          sr_req_i,
   input  logic          pend_nz_i,
   input  logic          tdone_i,
   output logic          ld_o,
   output logic [TW-1:0] ld_val_o,
   output logic          dec_o,
   output logic          in_self_o,
   output logic          req_o,
   output cmd_t          cmd_o
);
   localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 2);
   localparam logic [TW-1:0] RC_LD  = TW'(T_RC - 2);
   localparam logic [TW-1:0] XIT_LD = TW'(T_RC - 1);

   rf_state_e st_q, st_d;
   logic      want;

   assign want = pend_nz_i || sr_req_i;

   always_comb begin
      st_d     = st_q;
      ld_o     = 1'b0;
      ld_val_o = '0;
      case (st_q)
         ST_IDLE: if (want && gnt_i)
                     st_d = !banks_idle_i ? ST_PRE : (sr_req_i ? ST_SRE : ST_REF);
         ST_PRE:  begin st_d = ST_WRP; ld_o = 1'b1; ld_val_o = RP_LD; end
         ST_WRP:  if (tdone_i) st_d = sr_req_i ? ST_SRE : ST_REF;
         ST_REF:  begin st_d = ST_WRC; ld_o = 1'b1; ld_val_o = RC_LD; end
         ST_WRC:  if (tdone_i) begin
                     if (sr_req_i && gnt_i)       st_d = ST_SRE;
                     else if (pend_nz_i && gnt_i) st_d = ST_REF;
                     else                         st_d = ST_IDLE;
                  end
         ST_SRE:  st_d = ST_SELF;
         ST_SELF: if (!sr_req_i) begin st_d = ST_XIT; ld_o = 1'b1; ld_val_o = XIT_LD; end
         ST_XIT:  if (tdone_i) st_d = ST_REF;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      case (st_q)
         ST_PRE:  cmd_o = CMD_PREA;
         ST_REF:  cmd_o = CMD_REF;
         ST_SRE:  cmd_o = CMD_SRE;
         ST_SELF: cmd_o = CMD_SLP;
         default: cmd_o = CMD_NOP;
      endcase
   end

   assign dec_o     = (st_q == ST_REF);
   assign in_self_o = (st_q == ST_SRE) || (st_q == ST_SELF);
   assign req_o     = (st_q != ST_IDLE) || want;

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
   import sdram_rfsh_pkg::*;
#(
   parameter int T_RC     = 9,
   parameter int T_RP     = 3,
   parameter int T_REFI   = 1040,
   parameter int MAX_PEND = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic gnt_i,
   input  logic banks_idle_i,
   input  logic sr_req_i,
   output logic req_o,
   output logic urgent_o,
   output logic cs_n_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o,
   output logic cke_o,
   output logic a10_o
);
   localparam int TMAX = (T_RC > T_RP) ? T_RC : T_RP;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int SW   = $clog2(T_RC + 1);

   initial begin
      assert (T_RC >= 2)        else $error("T_RC must be at least 2");
      assert (T_RP >= 2)        else $error("T_RP must be at least 2");
      assert (MAX_PEND >= 1)    else $error("MAX_PEND must be at least 1");
      assert (T_REFI > T_RC)    else $error("T_REFI must exceed T_RC");
   end

   logic          pend_nz, full, ld, dec, in_self, tdone;
   logic [TW-1:0] ld_val;
   cmd_t          cmd;

   rfsh_interval #(.T_REFI(T_REFI), .MAX_PEND(MAX_PEND)) u_ivl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(in_self),
      .dec_i(dec), .pend_nz_o(pend_nz), .full_o(full));

   rfsh_gap_timer #(.TW(TW)) u_gap (
      .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_val_i(ld_val), .done_o(tdone));

   rfsh_seq #(.T_RC(T_RC), .T_RP(T_RP), .TW(TW)) u_seq (
      .clk(clk), .rst_n(rst_n), .gnt_i(gnt_i), .banks_idle_i(banks_idle_i),
      .sr_req_i(sr_req_i), .pend_nz_i(pend_nz), .tdone_i(tdone),
      .ld_o(ld), .ld_val_o(ld_val), .dec_o(dec), .in_self_o(in_self),
      .req_o(req_o), .cmd_o(cmd));

   assign urgent_o = full;
   assign cs_n_o   = cmd.cs_n;
   assign ras_n_o  = cmd.ras_n;
   assign cas_n_o  = cmd.cas_n;
   assign we_n_o   = cmd.we_n;
   assign cke_o    = cmd.cke;
   assign a10_o    = cmd.a10;

   // Port-level observation for the checks below
   logic          is_cmd, is_ref, is_pre, cke_q, closed_q;
   logic [SW-1:0] since_q;

   assign is_cmd = !cs_n_o && !(ras_n_o && cas_n_o && we_n_o);
   assign is_ref = is_cmd && !ras_n_o && !cas_n_o && we_n_o && cke_o;
   assign is_pre = is_cmd && !ras_n_o && cas_n_o && !we_n_o && a10_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q  <= SW'(T_RC);
         cke_q    <= 1'b1;
         closed_q <= 1'b0;
      end else begin
         cke_q <= cke_o;
         if (is_ref || (cke_o && !cke_q)) since_q <= SW'(1);
         else if (since_q != SW'(T_RC))   since_q <= since_q + 1'b1;
         if (is_pre)      closed_q <= 1'b1;
         else if (!req_o) closed_q <= 1'b0;
      end
   end

   assert_ref_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmd |-> since_q >= SW'(T_RC));

   assert_sre_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (!cs_n_o && !ras_n_o && !cas_n_o && we_n_o));

   assert_ref_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> ($past(banks_idle_i) || closed_q));

   assert_urgent_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      urgent_o |-> req_o);

endmodule

// File: tb/sdram_refresh_mgr_tb.sv
module sdram_refresh_mgr_tb;
   localparam int CLK_PERIOD = 10;
   localparam int K_PRE = 1, K_REF = 2, K_SRE = 3, K_EXIT = 4, K_BAD = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_i = 1'b1, gnt_i = 1'b1, banks_idle_i = 1'b1, sr_req_i = 1'b0;
   logic req_o, urgent_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, a10_o;

   int    cyc = 0, checks = 0, errors = 0;
   int    exp_kind[$];
   int    exp_cyc[$];
   string exp_tag[$];
   logic  cke_prev = 1'b1;
   bit    done = 1'b0;

   sdram_refresh_mgr #(.T_RC(4), .T_RP(2), .T_REFI(20), .MAX_PEND(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gnt_i(gnt_i),
      .banks_idle_i(banks_idle_i), .sr_req_i(sr_req_i), .req_o(req_o),
      .urgent_o(urgent_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
      .cas_n_o(cas_n_o), .we_n_o(we_n_o), .cke_o(cke_o), .a10_o(a10_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(string tg, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tg, act, expv);
      end
   endtask

   task automatic expect_cmd(int k, int c, string tg);
      exp_kind.push_back(k);
      exp_cyc.push_back(c);
      exp_tag.push_back(tg);
   endtask

   task automatic at_cycle(int n);
      while (cyc != n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Monitor: turn port activity into command events and score them
   always @(negedge clk) begin : mon
      int    kind, ek, ec;
      string tg;
      kind = 0;
      if (rst_n && !done) begin
         if (cke_o && !cke_prev) kind = K_EXIT;
         else if (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) begin
            if (!ras_n_o && !cas_n_o && we_n_o)              kind = cke_o ? K_REF : K_SRE;
            else if (!ras_n_o && cas_n_o && !we_n_o && a10_o) kind = K_PRE;
            else                                              kind = K_BAD;
         end
         if (kind != 0) begin
            if (exp_kind.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R10: unexpected command kind %0d at cycle %0d, expected none", kind, cyc);
            end else begin
               ek = exp_kind.pop_front();
               ec = exp_cyc.pop_front();
               tg = exp_tag.pop_front();
               check({tg, " command kind"}, kind, ek);
               check({tg, " command cycle"}, cyc, ec);
            end
         end
         cke_prev = cke_o;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // Expected command stream (parameters T_RC=4, T_RP=2, T_REFI=20, MAX_PEND=3)
      expect_cmd(K_REF,  21,  "R4 first refresh");
      expect_cmd(K_REF,  41,  "R2 interval");
      expect_cmd(K_PRE,  61,  "R5 precharge-all");
      expect_cmd(K_REF,  63,  "R5 refresh after tRP");
      expect_cmd(K_REF,  151, "R3 refresh after grant");
      expect_cmd(K_REF,  155, "R6 back-to-back gap");
      expect_cmd(K_REF,  159, "R7 saturated drain");
      expect_cmd(K_REF,  163, "R7 drain plus new");
      expect_cmd(K_REF,  181, "R7 no extra refresh");
      expect_cmd(K_REF,  211, "R2 tick pause");
      expect_cmd(K_SRE,  221, "R8 self-refresh entry");
      expect_cmd(K_EXIT, 261, "R9 exit");
      expect_cmd(K_REF,  265, "R9 refresh after exit");
      expect_cmd(K_REF,  282, "R9 interval restart");

      repeat (3) @(posedge clk);
      #1;
      check("R1 reset command", {cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, a10_o}, 6'b011110);
      check("R1 reset req", req_o, 0);
      check("R1 reset urgent", urgent_o, 0);
      rst_n = 1'b1;

      at_cycle(10);
      check("R10 idle NOP", {cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, a10_o}, 6'b011110);
      check("R3 no request when nothing due", req_o, 0);

      at_cycle(50);  banks_idle_i = 1'b0;
      at_cycle(64);  banks_idle_i = 1'b1;
      at_cycle(70);  gnt_i = 1'b0;
      at_cycle(90);
      check("R3 request held without grant", req_o, 1);
      check("R7 urgent low below limit", urgent_o, 0);
      at_cycle(125);
      check("R7 urgent at limit", urgent_o, 1);
      at_cycle(150); gnt_i = 1'b1;
      at_cycle(152);
      check("R7 urgent clears after refresh", urgent_o, 0);
      at_cycle(184); tick_i = 1'b0;
      at_cycle(194); tick_i = 1'b1;
      at_cycle(220); sr_req_i = 1'b1;
      at_cycle(240);
      check("R8 cke held low", cke_o, 0);
      check("R8 NOP during self-refresh", {cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, a10_o}, 6'b011100);
      at_cycle(260); sr_req_i = 1'b0;
      at_cycle(300);
      done = 1'b1;
      while (exp_kind.size() > 0) begin
         checks++;
         errors++;
         $display("FAIL %s: actual missing expected command at cycle %0d",
                  exp_tag.pop_front(), exp_cyc.pop_front());
         void'(exp_kind.pop_front());
      end
      finish_run();
   end

endmodule